// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM. Reads and writes share one two-edge pipeline, so the data bus can switch from read to write and back on consecutive cycles without idle slots. A command is sampled on a rising edge. Read data is driven onto the bus after the second enabled edge that follows. Write data and its byte strobes are taken from the bus at that same second edge. The array is then updated under a per-lane mask. Each lane is one data byte plus one parity bit.

A load cycle takes an external address and fixes the burst direction. Advance cycles then walk a small burst counter through the low address bits and ignore the read/write pin. An active-low clock enable freezes every register, including the array, for the cycles in which it is high. The array is read one edge ahead of the output register. A write that commits on the same edge as that read is therefore merged into the read word.

Top module: `flow_sram`

## Requirements
- R1: With `adv_ld` low, the chip selected and the clock enabled, the edge loads `addr` as a new burst start. `rd_wr` high makes the burst a read and `rd_wr` low makes it a write.
- R2: With `adv_ld` high during an active burst, the next address is used. Its low `BURST_W` bits are one more than the previous beat, wrapping modulo 2^`BURST_W`, and its upper bits stay fixed. The burst keeps its loaded direction whatever `rd_wr` is.
- R3: With `adv_ld` low and the chip not selected, the burst ends. Two enabled edges later `dq_oe` is low.
- R4: When `clk_en_n` is high at an edge, no register, array word or output changes on that edge.
- R5: The chip is selected only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. Any other combination at a load cycle acts as a deselect and writes nothing.
- R6: `bw_n[i]` (active low) enables lane i. Lane i is data bits 8i+7..8i plus parity bit 32+i. Any set of lanes may be written together. With `bw_n` all ones, a write cycle leaves the array unchanged.
- R7: While reset is asserted, and after it is released until a read reaches the output, `dq_oe` is low.
- R8: A read sampled at edge k drives `dq_out` with `dq_oe` high after edge k+2. A write sampled at edge k captures `dq_in` and `bw_n` at edge k+2. The edges are counted as enabled edges only.
- R9: An advance cycle with no active burst (after reset or a deselect) performs no access, and `dq_oe` stays low for it.
- R10: A read sampled on the edge after a write to the same address returns the newly written lanes merged with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| clk_en_n | input | 1 | Active-low clock enable; high suspends the edge |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| adv_ld | input | 1 | High: advance burst; low: load address or deselect |
| rd_wr | input | 1 | Direction at load: high read, low write |
| bw_n | input | LANES | Active-low lane write strobes, sampled at data capture |
| addr | input | ADDR_W | Word address, sampled at load |
| dq_in | input | LANES*(BYTE_W+1) | Write data from the bus |
| dq_out | output | LANES*(BYTE_W+1) | Read data toward the bus |
| dq_oe | output | 1 | Output enable for `dq_out` |

## Verification
The bench uses the default parameters: 6 address bits (64 words), a 2-bit burst counter and four 9-bit lanes. With only 64 words, a few bursts are enough to cover every starting offset, including the offset-2 wrap across the boundary where the upper address bits must not change. The 36-bit word keeps the parity lanes in the masked-write cases. Back-to-back write/read pairs on a single address drive the same-edge merge path. Suspends are placed inside bursts, and during them the bench drives random values on every other input.

// File: rtl/flow_sram_pkg.sv
package flow_sram_pkg;

  // Kind of cycle sampled at a rising edge.
  typedef enum logic [1:0] {
    CYC_HOLD = 2'd0,  // clock enable inactive: edge blocked
    CYC_IDLE = 2'd1,  // deselect / end of burst
    CYC_LOAD = 2'd2,  // new external address
    CYC_ADV  = 2'd3   // step the burst counter
  } cyc_e;

  function automatic cyc_e classify(input logic en_n, input logic sel_ok, input logic adv);
    if (en_n) return CYC_HOLD;
    if (adv) return CYC_ADV;
    return sel_ok ? CYC_LOAD : CYC_IDLE;
  endfunction

  // Data bits come first, lane after lane; the parity bits follow, one per lane.
  function automatic int lane_of_bit(input int b, input int lanes, input int byte_w);
    if (b < lanes * byte_w) return b / byte_w;
    return b - lanes * byte_w;
  endfunction

endpackage

// File: rtl/flow_sram_store.sv
module flow_sram_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DATA_W-1:0] wmask,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= (wdata & wmask) | (mem[waddr] & ~wmask);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flow_sram_lanes.sv
module flow_sram_lanes
  import flow_sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * (BYTE_W + 1)
) (
  input  logic [LANES-1:0]  bw_n,
  output logic [DATA_W-1:0] mask
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam int LN = lane_of_bit(b, LANES, BYTE_W);
    assign mask[b] = ~bw_n[LN];
  end
endmodule

// File: rtl/flow_sram_ctl.sv
module flow_sram_ctl
  import flow_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              burst_act,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s2_vld,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  function automatic logic [BURST_W-1:0] beat_inc(input logic [BURST_W-1:0] c);
    return c + BURST_W'(1);
  endfunction

  logic              burst_wr;
  logic [HI_W-1:0]   burst_hi;
  logic [BURST_W-1:0] burst_cnt;
  logic [BURST_W-1:0] cnt_nxt;

  assign cnt_nxt = beat_inc(burst_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      burst_wr  <= 1'b0;
      burst_hi  <= '0;
      burst_cnt <= '0;
      s1_vld    <= 1'b0;
      s1_wr     <= 1'b0;
      s1_addr   <= '0;
      s2_vld    <= 1'b0;
      s2_wr     <= 1'b0;
      s2_addr   <= '0;
    end else if (cyc != CYC_HOLD) begin
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      case (cyc)
        CYC_LOAD: begin
          burst_act <= 1'b1;
          burst_wr  <= ~rd_wr;
          burst_hi  <= addr[ADDR_W-1:BURST_W];
          burst_cnt <= addr[BURST_W-1:0];
          s1_vld    <= 1'b1;
          s1_wr     <= ~rd_wr;
          s1_addr   <= addr;
        end
        CYC_ADV: begin
          if (burst_act) begin
            burst_cnt <= cnt_nxt;
            s1_vld    <= 1'b1;
            s1_wr     <= burst_wr;
            s1_addr   <= {burst_hi, cnt_nxt};
          end else begin
            s1_vld <= 1'b0;
          end
        end
        default: begin
          burst_act <= 1'b0;
          s1_vld    <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/flow_sram.sv
module flow_sram
  import flow_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int LANES   = 4,
  parameter int BYTE_W  = 8,
  localparam int DATA_W = LANES * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv_ld,
  input  logic              rd_wr,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] fresh,
    input logic [DATA_W-1:0] old,
    input logic [DATA_W-1:0] m
  );
    return (fresh & m) | (old & ~m);
  endfunction

  // Named events for the checker.
  logic sel_ok;
  cyc_e cyc;
  logic cyc_load;
  logic burst_act;
  logic s1_vld, s1_wr, s2_vld, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic commit_we;
  logic fwd_hit;
  logic [DATA_W-1:0] wmask, arr_word, rd_next, rd_q;

  assign sel_ok   = ~sel_a_n & sel_b & ~sel_c_n;
  assign cyc      = classify(clk_en_n, sel_ok, adv_ld);
  assign cyc_load = (cyc == CYC_LOAD);

  flow_sram_ctl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (cyc),
    .rd_wr    (rd_wr),
    .addr     (addr),
    .burst_act(burst_act),
    .s1_vld   (s1_vld),
    .s1_wr    (s1_wr),
    .s1_addr  (s1_addr),
    .s2_vld   (s2_vld),
    .s2_wr    (s2_wr),
    .s2_addr  (s2_addr)
  );

  flow_sram_lanes #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lanes (
    .bw_n(bw_n),
    .mask(wmask)
  );

  assign commit_we = (cyc != CYC_HOLD) & s2_vld & s2_wr;

  flow_sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .we   (commit_we),
    .wmask(wmask),
    .waddr(s2_addr),
    .wdata(dq_in),
    .raddr(s1_addr),
    .rdata(arr_word)
  );

  // The write committing on this edge is not yet visible in arr_word.
  assign fwd_hit = commit_we & (s1_addr == s2_addr);
  assign rd_next = fwd_hit ? lane_merge(dq_in, arr_word, wmask) : arr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else if (!clk_en_n) begin
      if (s1_vld & ~s1_wr) rd_q <= rd_next;
      if (s2_vld & ~s2_wr) dq_out <= rd_q;
      dq_oe <= s2_vld & ~s2_wr;
    end
  end
endmodule

// File: rtl/flow_sram_chk.sv
module flow_sram_chk #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int LANES   = 4,
  parameter int DATA_W  = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              adv_ld,
  input logic              rd_wr,
  input logic [ADDR_W-1:0] addr,
  input logic [LANES-1:0]  bw_n,
  input logic [DATA_W-1:0] dq_in,
  input logic              cyc_load,
  input logic              burst_act,
  input logic              s1_vld,
  input logic              s1_wr,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s2_vld,
  input logic              s2_wr,
  input logic [ADDR_W-1:0] s2_addr,
  input logic [DATA_W-1:0] rd_q,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  a_r1_load_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && cyc_load) |=> (s1_vld && s1_wr == !$past(rd_wr) && s1_addr == $past(addr)));

  a_r2_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && burst_act) |=>
      (s1_vld && s1_wr == $past(s1_wr)
       && s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])
       && s1_addr[BURST_W-1:0] == BURST_W'($past(s1_addr[BURST_W-1:0]) + 1'b1)));

  a_r3_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !s2_vld) |=> !dq_oe);

  a_r4_suspend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(dq_oe) && $stable(dq_out) && $stable(rd_q)
                  && $stable(s1_vld) && $stable(s1_addr) && $stable(s2_vld) && $stable(s2_addr)));

  a_r7_reset_hiz: assert property (@(posedge clk) !rst_n |=> !dq_oe);

  a_r8_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_vld && !s2_wr) |=> dq_oe);

  a_r10_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s1_vld && !s1_wr && s2_vld && s2_wr && s1_addr == s2_addr && bw_n == '0)
      |=> (rd_q == $past(dq_in)));
endmodule

bind flow_sram flow_sram_chk #(
  .ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld), .rd_wr(rd_wr),
  .addr(addr), .bw_n(bw_n), .dq_in(dq_in), .cyc_load(cyc_load), .burst_act(burst_act),
  .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s2_vld(s2_vld), .s2_wr(s2_wr),
  .s2_addr(s2_addr), .rd_q(rd_q), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/flow_sram_test.sv
`timescale 1ns/1ps
module flow_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam logic [2:0] SEL_ON = 3'b010;  // {sel_a_n, sel_b, sel_c_n}
  localparam bit WR = 1'b0;
  localparam bit RD = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic adv_ld = 1'b0, rd_wr = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #2 clk = ~clk;  // 250 MHz

  flow_sram uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv_ld(adv_ld), .rd_wr(rd_wr), .bw_n(bw_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct { bit oe; logic [DW-1:0] data; string tag; } exp_t;
  typedef struct { bit vld; bit wr; logic [AW-1:0] a; string tag; } cmd_t;

  exp_t q[$];
  exp_t last;
  cmd_t p1, p2;
  logic [DW-1:0] mem_m [1<<AW];
  bit b_act = 0, b_wr = 0;
  logic [AW-1:0] b_addr = '0;
  int checks = 0, errs = 0;
  bit done = 0;

  function automatic int lane(input int b);
    return (b >= 32) ? (b - 32) : (b >> 3);
  endfunction

  // Driver: drives one cycle and pushes what the outputs must show after its edge.
  task automatic step(input bit en, input bit adv, input logic [2:0] sel, input bit rw,
                      input logic [AW-1:0] a, input logic [3:0] bw, input string tag);
    logic [DW-1:0] din;
    exp_t e;
    cmd_t nc;
    din = DW'({$urandom(), $urandom()});
    @(negedge clk);
    clk_en_n = !en; adv_ld = adv; {sel_a_n, sel_b, sel_c_n} = sel;
    rd_wr = rw; addr = a; bw_n = bw; dq_in = din;
    if (!en) begin
      e = last;
      e.tag = "R4 suspend";
    end else begin
      if (p2.vld && p2.wr)
        for (int b = 0; b < DW; b++) if (!bw[lane(b)]) mem_m[p2.a][b] = din[b];
      e.oe = p2.vld && !p2.wr;
      e.data = e.oe ? mem_m[p2.a] : last.data;
      e.tag = p2.tag;
      nc.vld = 0; nc.wr = 0; nc.a = a; nc.tag = tag;
      if (!adv) begin
        if (sel == SEL_ON) begin
          b_act = 1; b_wr = !rw; b_addr = a;
          nc.vld = 1; nc.wr = !rw; nc.a = a;
        end else b_act = 0;
      end else if (b_act) begin
        b_addr = {b_addr[AW-1:2], 2'(b_addr[1:0] + 2'd1)};
        nc.vld = 1; nc.wr = b_wr; nc.a = b_addr;
      end
      p2 = p1; p1 = nc;
    end
    q.push_back(e);
    last = e;
  endtask

  task automatic ld(input bit rw, input logic [AW-1:0] a, input string tag, input logic [3:0] bw = 4'h0);
    step(1, 0, SEL_ON, rw, a, bw, tag);
  endtask
  task automatic adv(input bit rw, input string tag, input logic [3:0] bw = 4'h0);
    step(1, 1, SEL_ON, rw, AW'($urandom()), bw, tag);
  endtask
  task automatic idle(input string tag, input logic [3:0] bw = 4'h0);
    step(1, 0, 3'b000, RD, '0, bw, tag);
  endtask
  task automatic desel(input logic [2:0] sel, input bit rw, input logic [AW-1:0] a, input string tag);
    step(1, 0, sel, rw, a, 4'h0, tag);
  endtask
  task automatic sus();
    step(0, 1'($urandom()), 3'($urandom()), 1'($urandom()), AW'($urandom()), 4'($urandom()), "R4");
  endtask

  // Monitor: compares after each edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (dq_oe !== e.oe || (e.oe && dq_out !== e.data)) begin
          errs++;
          $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", e.tag, dq_oe, dq_out, e.oe, e.data);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    p1 = '{0, 0, '0, "R9"}; p2 = '{0, 0, '0, "R9"};
    last = '{0, '0, "R7"};
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin
      errs++;
      $display("FAIL R7: oe=%b expected oe=0 during reset", dq_oe);
    end
    rst_n = 1'b1;
    idle("R7"); idle("R7");

    // R1 / R2 / R8: write burst (rd_wr toggled on advances), then read it back.
    ld(WR, 6'd4, "R1"); adv(RD, "R2"); adv(RD, "R2"); adv(WR, "R2");
    ld(RD, 6'd4, "R8"); adv(WR, "R2"); adv(WR, "R2"); adv(RD, "R2");
    idle("R3"); idle("R3"); idle("R3");

    // R2 wrap from offset 2: 38,39,36,37.
    ld(WR, 6'd38, "R2"); adv(RD, "R2"); adv(RD, "R2"); adv(RD, "R2");
    ld(RD, 6'd36, "R2"); adv(RD, "R2"); adv(RD, "R2"); adv(RD, "R2");
    idle("R3"); idle("R3");

    // R6: full write, partial lanes 0 and 2, then no-lane write, then read.
    ld(WR, 6'd20, "R6"); idle("R6"); idle("R6", 4'h0);
    ld(WR, 6'd20, "R6"); idle("R6"); idle("R6", 4'b1010);
    ld(RD, 6'd20, "R6"); idle("R6"); idle("R6");
    ld(WR, 6'd20, "R6"); idle("R6"); idle("R6", 4'b1111);
    ld(RD, 6'd20, "R6"); idle("R6"); idle("R6"); idle("R6");

    // R10: read right after write to the same word, full and partial lanes.
    ld(WR, 6'd50, "R10"); ld(RD, 6'd50, "R10"); ld(WR, 6'd50, "R10");
    ld(RD, 6'd50, "R10", 4'h0); ld(WR, 6'd51, "R10", 4'b0110); ld(RD, 6'd50, "R10");
    ld(WR, 6'd50, "R10"); ld(RD, 6'd50, "R10", 4'h0); idle("R10", 4'b0101); idle("R10"); idle("R10");

    // R4: suspends inside write and read bursts.
    ld(WR, 6'd12, "R4"); sus(); sus(); adv(RD, "R4"); sus(); adv(RD, "R4"); adv(RD, "R4");
    ld(RD, 6'd12, "R4"); sus(); adv(WR, "R4"); adv(WR, "R4"); sus(); sus(); adv(WR, "R4");
    idle("R3"); sus(); idle("R3"); idle("R3");

    // R5: each select false alone, with write and read attempts to word 4.
    desel(3'b110, WR, 6'd4, "R5"); desel(3'b000, WR, 6'd4, "R5"); desel(3'b011, WR, 6'd4, "R5");
    desel(3'b110, RD, 6'd4, "R5"); desel(3'b000, RD, 6'd4, "R5"); desel(3'b011, RD, 6'd4, "R5");
    idle("R5"); idle("R5");
    ld(RD, 6'd4, "R5"); idle("R5"); idle("R5"); idle("R5");

    // R9: advance with no active burst after a deselect.
    ld(RD, 6'd5, "R3"); idle("R3"); adv(RD, "R9"); adv(WR, "R9"); adv(RD, "R9");
    idle("R9"); idle("R9");

    // R3: deselect in the middle of a read burst.
    ld(RD, 6'd36, "R3"); adv(RD, "R3"); idle("R3"); adv(RD, "R9"); idle("R3"); idle("R3");

    @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule